// File: doc/BRIEF.md
# Preemptive Table-RAM Bus Arbiter

Seven maintenance and search engines share one table-RAM bus. This arbiter decides each cycle which of them owns that bus. Each engine raises a request and holds it until its operation is over. It works only while its grant bit is high. It pulses done in its last granted cycle. A higher-ranked engine takes the bus away from a lower-ranked one in mid operation. The engine that loses the bus gets a one-cycle preemption pulse. It stalls while keeping its request high, and it resumes when the bus comes back.

The add and delete engines share one rank, and a rule of their own applies to them. Whichever of the two is granted first locks out its peer until it finishes. This holds even while it is suspended. Only the lookup engine can break into an add or delete. When add and delete both ask in the same cycle, add wins. The initialise engine ranks above all others and cannot be preempted. Host register accesses sit low in the order, so their latency depends on the traffic above them.

Top module: `ram_bus_arbiter`

## Requirements
- R1: Bit positions in every vector are 0 initialise, 1 lookup, 2 add, 3 delete, 4 register access, 5 find, 6 age. When the bus is free, the highest-ranked eligible requester is granted at the next clock edge. The rank order is 0, 1, {2,3}, 4, 5, 6.
- R2: `op_gnt` is one-hot or zero at all times, and it is zero while `rst` is high.
- R3: A requester of higher rank takes the bus from a lower-ranked holder that is mid operation, at the next clock edge.
- R4: A holder that keeps requesting and does not pulse done keeps its grant unless it is preempted. A done pulse, or a dropped request, releases the bus at the next edge. An operation that pulses done is not re-granted at that same edge.
- R5: Once add (or delete) has been granted, its peer is not granted until the lock is cleared. While add or delete holds the bus, only lookup can take it away.
- R6: If add and delete are both eligible while the pair is unlocked and nothing of higher rank competes, add is granted.
- R7: The pair lock clears on a done from the granted add or delete, on a done from the granted initialise, or when the locked engine withdraws its request. The peer may be granted at that same edge.
- R8: Initialise is never preempted. If it is requesting when reset is released, it is granted at the first edge after reset.
- R9: `op_preempt` pulses for exactly one cycle, in the same cycle that the grant falls. The affected bit belongs to the holder that lost the bus while still requesting and not finishing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_req | input | 7 | Request, one bit per engine, held for the whole operation |
| op_done | input | 7 | Completion pulse from the granted engine |
| op_gnt | output | 7 | Registered one-hot bus grant |
| op_preempt | output | 7 | One-cycle pulse to a holder that lost the bus |

## Verification
The hardest situation to reach is an add that lookup has suspended and that then withdraws its request while delete is waiting. That withdrawal must clear the lock, so delete wins once lookup finishes. A directed sequence steers the bus through that exact order. A long randomised phase follows, in which engines start, finish and occasionally abandon operations. A behavioural model in the bench tracks holder and lock state, and it is compared with both outputs on every cycle.

// File: rtl/ram_arb_pkg.sv
package ram_arb_pkg;

    localparam int OP_COUNT = 7;

    typedef enum logic [2:0] {
        OP_INIT   = 3'd0,
        OP_LOOKUP = 3'd1,
        OP_ADD    = 3'd2,
        OP_DEL    = 3'd3,
        OP_REG    = 3'd4,
        OP_FIND   = 3'd5,
        OP_AGE    = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        PAIR_FREE = 2'd0,
        PAIR_ADD  = 2'd1,
        PAIR_DEL  = 2'd2
    } pair_e;

    typedef logic [OP_COUNT-1:0] opvec_t;

    typedef struct packed {
        opvec_t gnt;
        opvec_t preempt;
    } arb_out_t;

    function automatic opvec_t bit_of(op_e o);
        return opvec_t'(1) << o;
    endfunction

endpackage

// File: rtl/arb_first_pick.sv
module arb_first_pick #(
    parameter int WIDTH = 7
) (
    input  logic [WIDTH-1:0] cand,
    output logic [WIDTH-1:0] first
);
    logic [WIDTH-1:0] seen;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pick
            if (i == 0) begin : g_head
                assign first[i] = cand[i];
                assign seen[i]  = cand[i];
            end else begin : g_tail
                assign first[i] = cand[i] & ~seen[i-1];
                assign seen[i]  = seen[i-1] | cand[i];
            end
        end
    endgenerate
endmodule

// File: rtl/arb_candidates.sv
module arb_candidates
    import ram_arb_pkg::*;
(
    input  opvec_t gnt_q,
    input  opvec_t req,
    input  opvec_t done,
    input  pair_e  lock_eff,
    output opvec_t cand
);
    opvec_t elig;

    always_comb begin
        // a holder that signals done is not eligible at the same edge
        elig = req & ~(gnt_q & done);
        cand = elig;
        case (lock_eff)
            PAIR_ADD: cand[OP_DEL] = 1'b0;
            PAIR_DEL: cand[OP_ADD] = 1'b0;
            default:  ;
        endcase
        if (gnt_q[OP_INIT] && elig[OP_INIT]) begin
            cand = bit_of(OP_INIT);
        end else if (gnt_q[OP_ADD] && elig[OP_ADD]) begin
            cand = elig & (bit_of(OP_ADD) | bit_of(OP_LOOKUP));
        end else if (gnt_q[OP_DEL] && elig[OP_DEL]) begin
            cand = elig & (bit_of(OP_DEL) | bit_of(OP_LOOKUP));
        end
    end
endmodule

// File: rtl/arb_pair_lock.sv
module arb_pair_lock
    import ram_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  opvec_t gnt_q,
    input  opvec_t req,
    input  opvec_t done,
    input  opvec_t gnt_nxt,
    output pair_e  lock_eff,
    output pair_e  lock_q
);
    logic  clear;
    pair_e lock_d;

    always_comb begin
        clear = (gnt_q[OP_INIT] & done[OP_INIT])
              | (gnt_q[OP_ADD]  & done[OP_ADD])
              | (gnt_q[OP_DEL]  & done[OP_DEL])
              | ((lock_q == PAIR_ADD) & ~req[OP_ADD])
              | ((lock_q == PAIR_DEL) & ~req[OP_DEL]);
        lock_eff = clear ? PAIR_FREE : lock_q;
        if (gnt_nxt[OP_ADD]) begin
            lock_d = PAIR_ADD;
        end else if (gnt_nxt[OP_DEL]) begin
            lock_d = PAIR_DEL;
        end else begin
            lock_d = lock_eff;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= PAIR_FREE;
        end else begin
            lock_q <= lock_d;
        end
    end
endmodule

// File: rtl/ram_bus_arbiter.sv
module ram_bus_arbiter
    import ram_arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [OP_COUNT-1:0] op_req,
    input  logic [OP_COUNT-1:0] op_done,
    output logic [OP_COUNT-1:0] op_gnt,
    output logic [OP_COUNT-1:0] op_preempt
);
    arb_out_t state_q;
    arb_out_t state_d;
    opvec_t   cand;
    opvec_t   gnt_nxt;
    pair_e    lock_eff;
    pair_e    lock_q;

    arb_pair_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .gnt_q    (state_q.gnt),
        .req      (op_req),
        .done     (op_done),
        .gnt_nxt  (gnt_nxt),
        .lock_eff (lock_eff),
        .lock_q   (lock_q)
    );

    arb_candidates u_cand (
        .gnt_q    (state_q.gnt),
        .req      (op_req),
        .done     (op_done),
        .lock_eff (lock_eff),
        .cand     (cand)
    );

    arb_first_pick #(.WIDTH(OP_COUNT)) u_pick (
        .cand  (cand),
        .first (gnt_nxt)
    );

    always_comb begin
        state_d.gnt     = gnt_nxt;
        // lost the bus while still mid operation
        state_d.preempt = state_q.gnt & ~gnt_nxt & op_req & ~op_done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign op_gnt     = state_q.gnt;
    assign op_preempt = state_q.preempt;
endmodule

// File: rtl/ram_bus_arbiter_chk.sv
module ram_bus_arbiter_chk
    import ram_arb_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [OP_COUNT-1:0] op_req,
    input logic [OP_COUNT-1:0] op_done,
    input logic [OP_COUNT-1:0] op_gnt,
    input logic [OP_COUNT-1:0] op_preempt
);
    always_comb begin
        AST_GNT_ONEHOT: assert ($onehot0(op_gnt)); // R2
    end

    AST_GNT_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        (op_gnt != '0) |-> (($past(op_req) & op_gnt) == op_gnt)); // R1

    AST_INIT_KEPT: assert property (@(posedge clk) disable iff (rst)
        (op_gnt[OP_INIT] && op_req[OP_INIT] && !op_done[OP_INIT]) |=> op_gnt[OP_INIT]); // R8

    AST_ADD_ONLY_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        (op_gnt[OP_ADD] && op_req[OP_ADD] && !op_done[OP_ADD])
        |=> (op_gnt[OP_ADD] || op_gnt[OP_LOOKUP])); // R5

    AST_DEL_ONLY_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        (op_gnt[OP_DEL] && op_req[OP_DEL] && !op_done[OP_DEL])
        |=> (op_gnt[OP_DEL] || op_gnt[OP_LOOKUP])); // R5

    AST_NO_PEER_SWAP: assert property (@(posedge clk) disable iff (rst)
        (op_gnt[OP_ADD] && op_req[OP_ADD] && !op_done[OP_ADD]) |=> !op_gnt[OP_DEL]); // R5

    AST_LOOKUP_TAKES: assert property (@(posedge clk) disable iff (rst)
        (op_req[OP_LOOKUP] && !op_req[OP_INIT] && !op_gnt[OP_INIT]
         && !(op_gnt[OP_LOOKUP] && op_done[OP_LOOKUP])) |=> op_gnt[OP_LOOKUP]); // R3

    AST_PREEMPT_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        (op_preempt & (op_gnt | ~$past(op_gnt))) == '0); // R9

    AST_PREEMPT_PULSE: assert property (@(posedge clk) disable iff (rst)
        (op_preempt != '0) |=> (op_preempt & $past(op_preempt)) == '0); // R9
endmodule

bind ram_bus_arbiter ram_bus_arbiter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_req     (op_req),
    .op_done    (op_done),
    .op_gnt     (op_gnt),
    .op_preempt (op_preempt)
);

// File: tb/ram_bus_arbiter_bench.sv
`timescale 1ns/100ps
module ram_bus_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] req = '0;
    logic [6:0] done = '0;
    logic [6:0] gnt;
    logic [6:0] pre;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference state
    int         m_holder = -1;
    int         m_lock = -1;
    logic [6:0] m_gnt = '0;
    logic [6:0] m_pre = '0;
    int         work [7];

    always #2.5 clk = ~clk;

    ram_bus_arbiter u_ram_bus_arbiter (
        .clk(clk), .rst(rst), .op_req(req), .op_done(done),
        .op_gnt(gnt), .op_preempt(pre)
    );

    task automatic chk(input bit ok, input string tag, input logic [6:0] act, input logic [6:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        int lk;
        int nw;
        int h;
        if (rst) begin
            m_holder = -1; m_lock = -1; m_gnt = '0; m_pre = '0;
        end else begin
            h  = m_holder;
            lk = m_lock;
            if (h == 0 && done[0]) lk = -1;
            if ((h == 2 || h == 3) && done[h]) lk = -1;
            if (lk >= 0 && !req[lk]) lk = -1;
            nw = -1;
            if (h == 0 && req[0] && !done[0]) nw = 0;
            else if ((h == 2 || h == 3) && req[h] && !done[h]) nw = req[1] ? 1 : h;
            else begin
                for (int i = 0; i < 7; i++) begin
                    if (nw < 0 && req[i] && !(i == h && done[i])
                        && !(lk == 2 && i == 3) && !(lk == 3 && i == 2)) nw = i;
                end
            end
            m_pre = '0;
            if (h >= 0 && nw != h && req[h] && !done[h]) m_pre[h] = 1'b1;
            if (nw == 2 || nw == 3) lk = nw;
            m_lock = lk;
            m_holder = nw;
            m_gnt = (nw >= 0) ? (7'd1 << nw) : 7'd0;
        end
    end

    always @(negedge clk) begin
        chk(gnt == m_gnt, "R1 R3 R4 R5 R7 grant vs model", gnt, m_gnt);
        chk(pre == m_pre, "R9 preempt vs model", pre, m_pre);
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        req = 7'h01;
        repeat (3) step();
        chk(gnt == 7'h00, "R2 zero in reset", gnt, 7'h00);
        rst = 1'b0;
        step();
        chk(gnt == 7'h01, "R8 init granted after reset", gnt, 7'h01);
        req = 7'h03; step();
        chk(gnt == 7'h01, "R8 init not preempted by lookup", gnt, 7'h01);
        done = 7'h01; step();
        chk(gnt == 7'h02, "R4 init done releases to lookup", gnt, 7'h02);
        chk(pre == 7'h00, "R9 no pulse on done", pre, 7'h00);
        req = 7'h0E; done = 7'h02; step();
        chk(gnt == 7'h04, "R6 add wins tie with delete", gnt, 7'h04);
        done = 7'h00; step();
        chk(gnt == 7'h02, "R3 lookup preempts add", gnt, 7'h02);
        chk(pre == 7'h04, "R9 add told of preemption", pre, 7'h04);
        step();
        chk(pre == 7'h00, "R9 pulse lasts one cycle", pre, 7'h00);
        done = 7'h02; step();
        chk(gnt == 7'h04, "R5 suspended add resumes over delete", gnt, 7'h04);
        req = 7'h0C; done = 7'h00; step();
        chk(gnt == 7'h04, "R4 add keeps grant", gnt, 7'h04);
        done = 7'h04; step();
        chk(gnt == 7'h08, "R7 add done unlocks delete", gnt, 7'h08);
        req = 7'h0C; done = 7'h00; step();
        chk(gnt == 7'h08, "R5 add locked out by delete", gnt, 7'h08);
        req = 7'h1C; step();
        chk(gnt == 7'h08, "R5 delete keeps bus against reg", gnt, 7'h08);
        req = 7'h14; step();
        chk(gnt == 7'h04, "R4 delete withdraws, add ranks over reg", gnt, 7'h04);
        done = 7'h04; step();
        chk(gnt == 7'h10, "R1 reg granted", gnt, 7'h10);
        req = 7'h70; done = 7'h00; step();
        chk(gnt == 7'h10, "R4 reg held against find and age", gnt, 7'h10);
        done = 7'h10; step();
        chk(gnt == 7'h20, "R1 find ranks over age", gnt, 7'h20);
        req = 7'h62; done = 7'h00; step();
        chk(gnt == 7'h02, "R3 lookup preempts find", gnt, 7'h02);
        chk(pre == 7'h20, "R9 find told of preemption", pre, 7'h20);
        done = 7'h02; step();
        chk(gnt == 7'h20, "R4 find resumes", gnt, 7'h20);
        req = 7'h00; done = 7'h00; step(); step();
        chk(gnt == 7'h00, "R4 bus idle", gnt, 7'h00);
        req = 7'h04; step();
        chk(gnt == 7'h04, "R1 add alone", gnt, 7'h04);
        req = 7'h06; step();
        chk(gnt == 7'h02, "R3 lookup preempts add again", gnt, 7'h02);
        req = 7'h0A; step();
        chk(gnt == 7'h02, "R5 lookup keeps bus", gnt, 7'h02);
        done = 7'h02; step();
        chk(gnt == 7'h08, "R7 withdrawn add frees delete", gnt, 7'h08);
        req = 7'h00; done = 7'h00; step(); step();

        for (int i = 0; i < 7; i++) work[i] = 0;
        repeat (4000) begin
            step();
            for (int i = 0; i < 7; i++) begin
                if (req[i]) begin
                    if (done[i]) begin
                        req[i] = 1'b0; done[i] = 1'b0;
                    end else if (gnt[i]) begin
                        if (work[i] == 0) done[i] = 1'b1;
                        else work[i]--;
                    end else if ($urandom_range(40) == 0) begin
                        req[i] = 1'b0;
                    end
                end else if ($urandom_range(i == 0 ? 300 : 8) == 0) begin
                    req[i] = 1'b1;
                    work[i] = $urandom_range(5);
                end
            end
        end
        step();
        finish_run();
    end
endmodule